// File: doc/BRIEF.md
# Programmable Peripheral Clock Generator

This block derives one peripheral clock from a small set of candidate input clocks. Four reference clocks and two external clocks enter the block; up to two cascaded stages each pick one of them, divide it by a programmable integer from 1 to 256 and may invert the result. The second stage can instead take the first stage's output, so the two dividers multiply. A glitch-free output enable and two gate-enable outputs, one for the bus clock and one for the peripheral-bus clock, complete the block.

Software programs it through a word-addressed register port with separate write and read strobes. The whole block runs on one fast system clock: the candidate clocks are sampled as levels, and each divider counts their rising edges. Every output phase is therefore a whole number of system cycles. A build with one stage takes its output straight from stage 0; the default build has two stages and takes the output from stage 1.

Top module: `pclkgen_top`

## Requirements
- R1: After reset, every register reads zero, `clk_o` is low, and both gate enables are low.
- R2: Word 0 is the control word, and stage k's word sits at word index 1+2k (stage 0 at index 1, stage 1 at index 3). Control bits [31:4] and stage bits 0 and [31:13] read back as zero whatever was written. Other word indices read zero and ignore writes. Read data appears on `reg_rdata` one cycle after `reg_rd`.
- R3: `bus_clk_en_o` is high only when control bits [1:0] are both set (value 3). `pbus_clk_en_o` follows control bit 3.
- R4: Stage bits [4:2] hold the source code and bits [12:5] hold the ratio N minus one. For an even N, the stage output has a period of N source periods and equal high and low phases.
- R5: For an odd N, the high phase lasts floor(N/2) source periods and the low phase ceil(N/2). N = 256 (field value 255) gives 128 source periods high and 128 low.
- R6: With N = 1 the selected source passes through unchanged. Codes 0 to 3 pick `src_clk_i[0]` to `src_clk_i[3]`, and codes 4 and 5 pick `src_clk_i[4]` and `src_clk_i[5]`.
- R7: Stage bit 1 inverts that stage's output, so an odd ratio then has the longer phase high.
- R8: In stage 1, source code 7 takes stage 0's output, so the ratios multiply. The final stage drives `clk_o`.
- R9: A source code that selects nothing (6 or 7 in stage 0, 6 in stage 1) holds that stage's output low.
- R10: Control bit 2 gates `clk_o`. Setting or clearing it takes effect only while the final stage output is low, so every high pulse on `clk_o` has its full length.
- R11: The low-power setting (stage 0 word with source 7 and ratio field 255, enable bit clear) keeps `clk_o` low, and the stage word reads back as 0x1FFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word index of the accessed register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after `reg_rd` |
| src_clk_i | input | NUM_SRC | Candidate clocks: four references, then two external |
| clk_o | output | 1 | Generated, gated peripheral clock |
| bus_clk_en_o | output | 1 | Bus-clock gate enable |
| pbus_clk_en_o | output | 1 | Peripheral-bus-clock gate enable |

## Verification
The bench measures the high and low phase lengths of `clk_o` for even, odd, unit and maximum ratios. A divider with an off-by-one half point would give equal phases for odd ratios or a wrong period, and one that mishandles N = 1 would divide by two. Chaining through code 7 is timed end to end, so a design that ignores the chain code or reads it in stage 0 produces the wrong period or a running clock. The enable is toggled in the middle of a high phase while the shortest pulse is tracked, and a gate that acts immediately leaves a clipped pulse that this check reports.

// File: rtl/pclkgen_pkg.sv
`timescale 1ns/1ps
package pclkgen_pkg;
  localparam int DIV_W = 8;
  localparam int SRC_W = 3;
  localparam int CFG_W = DIV_W + SRC_W + 1;
  localparam logic [SRC_W-1:0] SRC_CHAIN = 3'd7;

  typedef struct packed {
    logic [DIV_W-1:0] div_m1;
    logic [SRC_W-1:0] src;
    logic             inv;
  } stage_cfg_t;

  typedef struct packed {
    logic       pbus_en;
    logic       out_en;
    logic [1:0] bus_gate;
  } ctrl_t;

  // number of source periods the divided output stays high: floor(N/2)
  function automatic logic [DIV_W-1:0] high_len(input logic [DIV_W-1:0] div_m1);
    logic [DIV_W:0] n;
    n = (DIV_W+1)'(div_m1) + (DIV_W+1)'(1);
    return DIV_W'(n >> 1);
  endfunction

  function automatic stage_cfg_t cfg_from_word(input logic [31:0] w);
    return stage_cfg_t'(w[CFG_W:1]);
  endfunction

  function automatic logic [31:0] word_from_cfg(input stage_cfg_t c);
    return 32'({c, 1'b0});
  endfunction
endpackage

// File: rtl/pclkgen_regs.sv
`timescale 1ns/1ps
module pclkgen_regs
  import pclkgen_pkg::*;
#(
  parameter int NUM_STAGES = 2,
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output ctrl_t             ctrl_q,
  output stage_cfg_t        cfg_q   [NUM_STAGES],
  output logic              restart [NUM_STAGES]
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic [DATA_W-1:0] rd_val;
  logic [31:0]       wd32;
  assign wd32 = 32'(reg_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (reg_wr && reg_addr == '0) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
  end

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_cfg
    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(1 + 2 * k);
    assign restart[k] = reg_wr && (reg_addr == SLOT);
    always_ff @(posedge clk) begin
      if (!rst_n) cfg_q[k] <= '0;
      else if (restart[k]) cfg_q[k] <= cfg_from_word(wd32);
    end
  end

  always_comb begin
    rd_val = '0;
    if (reg_addr == '0) rd_val = DATA_W'(ctrl_q);
    for (int k = 0; k < NUM_STAGES; k++)
      if (reg_addr == ADDR_W'(1 + 2 * k)) rd_val = DATA_W'(word_from_cfg(cfg_q[k]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end

  AST_RD_CTRL_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_rd) && $past(reg_addr) == '0) |-> (reg_rdata >> CTRL_W) == '0); // R2
endmodule

// File: rtl/pclkgen_stage.sv
`timescale 1ns/1ps
module pclkgen_stage
  import pclkgen_pkg::*;
#(
  parameter int NUM_SRC  = 6,
  parameter bit CHAIN_OK = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  stage_cfg_t         cfg,
  input  logic               restart,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic               chain_lvl,
  output logic               out_lvl
);
  localparam int SEL_SPAN = 2 ** SRC_W;

  logic [SEL_SPAN-1:0] src_pad;
  logic                sel, none, lvl_d, rise, raw;
  logic [DIV_W-1:0]    cnt;

  assign src_pad = SEL_SPAN'(src_lvl);

  always_comb begin
    none = 1'b1;
    sel  = 1'b0;
    if (int'(cfg.src) < NUM_SRC) begin
      none = 1'b0;
      sel  = src_pad[cfg.src];
    end else if (CHAIN_OK && cfg.src == SRC_CHAIN) begin
      none = 1'b0;
      sel  = chain_lvl;
    end
  end

  assign rise = sel & ~lvl_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_d <= 1'b0;
      cnt   <= '0;
    end else begin
      lvl_d <= sel;
      if (restart)   cnt <= '0;
      else if (rise) cnt <= (cnt == cfg.div_m1) ? '0 : cnt + 1'b1;
    end
  end

  always_comb begin
    if (none)                  raw = 1'b0;
    else if (cfg.div_m1 == '0) raw = sel;
    else                       raw = (cnt < high_len(cfg.div_m1));
  end

  assign out_lvl = none ? 1'b0 : (raw ^ cfg.inv);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= cfg.div_m1); // R5
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !restart) |=> $stable(cnt)); // R4
endmodule

// File: rtl/pclkgen_gate.sv
`timescale 1ns/1ps
module pclkgen_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic out_en,
  input  logic fin,
  output logic clk_o
);
  logic run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   run_q <= 1'b0;
    else if (!fin) run_q <= out_en;
  end

  assign clk_o = fin & run_q;

  AST_OFF_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en && !clk_o) |=> !clk_o); // R10
  AST_FALL_WITH_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_o) |-> !fin); // R10
endmodule

// File: rtl/pclkgen_top.sv
`timescale 1ns/1ps
module pclkgen_top
  import pclkgen_pkg::*;
#(
  parameter int NUM_STAGES = 2,
  parameter int NUM_SRC    = 6,
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_SRC-1:0] src_clk_i,
  output logic               clk_o,
  output logic               bus_clk_en_o,
  output logic               pbus_clk_en_o
);
  ctrl_t              ctrl_q;
  stage_cfg_t         cfg_q   [NUM_STAGES];
  logic               restart [NUM_STAGES];
  logic [NUM_STAGES-1:0] stage_out;
  logic [NUM_SRC-1:0] src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_clk_i;
  end

  pclkgen_regs #(
    .NUM_STAGES(NUM_STAGES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ctrl_q(ctrl_q), .cfg_q(cfg_q), .restart(restart)
  );

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    logic chain_in;
    if (k == 0) begin : g_first
      assign chain_in = 1'b0;
    end else begin : g_next
      assign chain_in = stage_out[k-1];
    end
    pclkgen_stage #(.NUM_SRC(NUM_SRC), .CHAIN_OK(k > 0)) i_stage (
      .clk(clk), .rst_n(rst_n), .cfg(cfg_q[k]), .restart(restart[k]),
      .src_lvl(src_q), .chain_lvl(chain_in), .out_lvl(stage_out[k])
    );
  end

  pclkgen_gate i_gate (
    .clk(clk), .rst_n(rst_n), .out_en(ctrl_q.out_en),
    .fin(stage_out[NUM_STAGES-1]), .clk_o(clk_o)
  );

  assign bus_clk_en_o  = &ctrl_q.bus_gate;
  assign pbus_clk_en_o = ctrl_q.pbus_en;
endmodule

// File: tb/test_pclkgen_top.sv
`timescale 1ns/1ps
module test_pclkgen_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [5:0]  src = '0;
  logic        clk_o, bus_en, pbus_en;
  int checks = 0, failures = 0;
  bit done = 0;
  bit arm = 0;
  int hcnt = 0, min_high = 999;

  always #5 clk = ~clk;

  pclkgen_top i_pclkgen_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_clk_i(src), .clk_o(clk_o), .bus_clk_en_o(bus_en), .pbus_clk_en_o(pbus_en)
  );

  // source i toggles every i+1 cycles: period 2*(i+1)
  initial begin
    int cnt [6];
    for (int i = 0; i < 6; i++) cnt[i] = 0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < 6; i++) begin
        cnt[i]++;
        if (cnt[i] == i + 1) begin cnt[i] = 0; src[i] = ~src[i]; end
      end
    end
  end

  // shortest completed high pulse while armed
  always @(negedge clk) begin
    if (!arm) begin min_high = 999; hcnt = 0; end
    else if (clk_o) hcnt++;
    else begin
      if (hcnt > 0 && hcnt < min_high) min_high = hcnt;
      hcnt = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = 3'(a);
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  function automatic logic [31:0] sw(input int s, input int n, input int inv);
    return 32'(((n - 1) << 5) | (s << 2) | (inv << 1));
  endfunction

  task automatic wait_level(input logic v, output bit ok);
    int t = 0;
    ok = 1;
    do begin @(negedge clk); t++; end while (clk_o !== v && t < 3000);
    if (t >= 3000) ok = 0;
  endtask

  task automatic measure(output int hi, output int lo);
    bit ok;
    hi = -1; lo = -1;
    wait_level(0, ok); if (!ok) return;
    wait_level(1, ok); if (!ok) return;
    wait_level(0, ok); if (!ok) return;
    wait_level(1, ok); if (!ok) return;
    hi = 0; lo = 0;
    while (clk_o === 1'b1 && hi < 3000) begin hi++; @(negedge clk); end
    while (clk_o === 1'b0 && lo < 3000) begin lo++; @(negedge clk); end
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (clk_o) h++; end
  endtask

  task automatic run_pair(input string tag, input int ehi, input int elo);
    int hi, lo;
    measure(hi, lo);
    chk({tag, " high"}, hi, ehi);
    chk({tag, " low"}, lo, elo);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 clk_o", int'(clk_o), 0);
    chk("R1 bus_en", int'(bus_en), 0);
    chk("R1 pbus_en", int'(pbus_en), 0);
    rd(0, d); chk("R1 ctrl", int'(d), 0);
    rd(1, d); chk("R1 stage0", int'(d), 0);
    rd(3, d); chk("R1 stage1", int'(d), 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(0, 32'hFFFF_FFF0); rd(0, d); chk("R2 ctrl rsvd", int'(d), 0);
    wr(1, 32'hFFFF_FFFF); rd(1, d); chk("R2 stage0 mask", int'(d), 32'h1FFE);
    wr(3, 32'h0000_0AA5); rd(3, d); chk("R2 stage1 mask", int'(d), 32'h0AA4);
    wr(2, 32'h1234_5678); rd(2, d); chk("R2 unmapped", int'(d), 0);
    rd(1, d); chk("R2 stage0 kept", int'(d), 32'h1FFE);
  endtask

  task automatic t_gates();
    wr(0, 32'h1); chk("R3 bus partial", int'(bus_en), 0);
    wr(0, 32'h3); chk("R3 bus on", int'(bus_en), 1);
    chk("R3 pbus off", int'(pbus_en), 0);
    wr(0, 32'h8); chk("R3 pbus on", int'(pbus_en), 1);
    chk("R3 bus off", int'(bus_en), 0);
  endtask

  task automatic setup(input logic [31:0] s0, input logic [31:0] s1);
    wr(1, s0); wr(3, s1); wr(0, 32'h4);
  endtask

  task automatic t_even();
    setup(sw(1, 4, 0), sw(7, 1, 0)); run_pair("R4 src1 n4", 8, 8);
    setup(sw(0, 2, 0), sw(7, 1, 0)); run_pair("R4 src0 n2", 2, 2);
  endtask

  task automatic t_odd();
    setup(sw(2, 3, 0), sw(7, 1, 0));   run_pair("R5 src2 n3", 6, 12);
    setup(sw(3, 5, 0), sw(7, 1, 0));   run_pair("R5 src3 n5", 16, 24);
    setup(sw(0, 256, 0), sw(7, 1, 0)); run_pair("R5 src0 n256", 256, 256);
  endtask

  task automatic t_pass();
    setup(sw(0, 1, 0), sw(7, 1, 0)); run_pair("R6 src0 n1", 1, 1);
    setup(sw(4, 1, 0), sw(7, 1, 0)); run_pair("R6 ext src4 n1", 5, 5);
    setup(sw(5, 1, 0), sw(7, 1, 0)); run_pair("R6 ext src5 n1", 6, 6);
  endtask

  task automatic t_invert();
    setup(sw(0, 3, 1), sw(7, 1, 0)); run_pair("R7 stage0 inv n3", 4, 2);
    setup(sw(0, 3, 0), sw(7, 1, 1)); run_pair("R7 stage1 inv", 4, 2);
  endtask

  task automatic t_chain();
    setup(sw(0, 2, 0), sw(7, 3, 0)); run_pair("R8 chain 2x3", 4, 8);
    setup(sw(0, 2, 0), sw(3, 2, 0)); run_pair("R8 stage1 direct", 8, 8);
  endtask

  task automatic t_none();
    int h;
    setup(sw(6, 1, 0), sw(7, 1, 0)); count_high(100, h); chk("R9 stage0 code6", h, 0);
    setup(sw(7, 2, 0), sw(7, 1, 0)); count_high(100, h); chk("R9 stage0 code7", h, 0);
    setup(sw(0, 1, 0), sw(6, 1, 0)); count_high(100, h); chk("R9 stage1 code6", h, 0);
  endtask

  task automatic t_glitch();
    int h;
    bit ok;
    wr(0, 32'h0); wr(1, sw(0, 8, 0)); wr(3, sw(7, 1, 0));
    repeat (5) @(negedge clk);
    arm = 1;
    repeat (11) @(negedge clk);
    wr(0, 32'h4);
    repeat (100) @(negedge clk);
    wait_level(1, ok);
    repeat (3) @(negedge clk);
    wr(0, 32'h0);
    repeat (40) @(negedge clk);
    chk("R10 min high pulse", min_high, 8);
    count_high(40, h); chk("R10 stopped", h, 0);
    arm = 0;
  endtask

  task automatic t_lowpower();
    int h;
    logic [31:0] d;
    setup(sw(0, 2, 0), sw(7, 1, 0));
    repeat (20) @(negedge clk);
    wr(1, sw(7, 256, 0)); wr(0, 32'h0);
    count_high(600, h); chk("R11 low power quiet", h, 0);
    rd(1, d); chk("R11 word", int'(d), 32'h1FFC);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_gates();
    t_even();
    t_odd();
    t_pass();
    t_invert();
    t_chain();
    t_none();
    t_glitch();
    t_lowpower();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule